// File: doc/BRIEF.md
# Tri-State PWM Gate Sequencer

This block is the clocked control core of a synchronous buck half-bridge driver. It receives a PWM command that has already been digitised into three levels, plus a supervisor enable and four comparator results: the switch node is low, the low-side gate is sensed off, the high-side gate is sensed off, and the inductor current has reached zero. From these it produces the on/off commands for the high-side and low-side gates.

Each move from one switch to the other uses a break-before-make sequence. The conducting gate is released first. The block then waits until the sensors confirm that this transistor is off, and runs a fixed dead-time count before the other gate closes. The middle PWM level selects diode emulation. The low side conducts for a blanking interval during which the zero-cross input is ignored. After that interval, the first zero-cross opens the low side and leaves both gates off.

Every exit from the high command arms a backup timer. If the switch node never reports low, the low side is forced on when the timer runs out, so that a shorted high-side switch blows the input fuse. All intervals are parameters counted in clock cycles.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: While `enable` is low, both gate outputs are low from the first clock edge that samples it, whatever the PWM code. When enable returns, sequencing restarts from both gates off towards the current PWM level.
- R2: `hsGate` and `lsGate` are never high in the same cycle.
- R3: On the high code, the low-side gate is released at the first edge that samples it. The high-side gate rises only once `lsGateOff` has been sampled high and `DEAD_CYC` further cycles have passed. With the sensor already high, `hsGate` is high DEAD_CYC+1 edges after the edge that first sampled the code.
- R4: On the low code from the high-side state, the high-side gate is released at once. The low-side gate rises only after `hsGateOff` and `swLow` are both sampled high, followed by `DEAD_CYC` cycles.
- R5: On the mid code, the high-side gate is off and the low-side gate rises after the same adaptive dead time. It then stays high for `BLANK_CYC` cycles regardless of `zeroCross`, and afterwards stays high for as long as `zeroCross` is low.
- R6: In the mid state after blanking, a sampled high `zeroCross` drops the low-side gate at the next edge. Both gates then stay low while the code remains mid.
- R7: Going from the low code to the mid code keeps the low side on and starts a fresh blanking interval. Going from the mid code to the low code clears the zero-cross state: the low side is turned on again, and a later mid code blanks again from the start.
- R8: Each edge that samples a non-high code right after a high code arms a timer of `TIMEOUT_CYC` cycles. If the low side is still waiting for the switch node when the timer expires, the low side turns on at edge TIMEOUT_CYC counted from that sampling edge, with no dead-time count. When expiry and the adaptive condition arrive together, expiry wins.
- R9: A change of PWM code while a wait or dead-time count is in progress abandons it. Both gates stay off and sequencing restarts towards the new level.
- R10: PWM code encoding: 2'b00 is low, 2'b01 is mid, 2'b10 is high, and 2'b11 is treated as mid.
- R11: During reset both gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Supervisor enable; low forces both gates off |
| pwmCode | input | 2 | Digitised PWM level (R10 encoding) |
| swLow | input | 1 | Switch node sensed below its low threshold |
| lsGateOff | input | 1 | Low-side gate sensed discharged |
| hsGateOff | input | 1 | High-side gate sensed discharged |
| zeroCross | input | 1 | Inductor current sensed at zero |
| hsGate | output | 1 | High-side gate command |
| lsGate | output | 1 | Low-side gate command |

## Verification
The backup timer and the adaptive low-side condition can both become ready in the same cycle while the sequencer waits for the high side to release. The bench holds the switch node high after leaving the high code and releases it exactly one cycle before the timer expires, so both conditions are sampled at the same edge. The result is judged by the cycle in which `lsGate` rises. If the timeout takes priority, the gate rises at the expiry edge. If the adaptive path wins, the dead-time count delays the rise by DEAD_CYC further cycles and the scoreboard reports the miss.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;

  typedef enum logic [1:0] {
    TGT_LOW,
    TGT_MID,
    TGT_HIGH
  } tgt_t;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_WAIT_LS_OFF,
    ST_DEAD_HI,
    ST_HS_ON,
    ST_WAIT_HS_OFF,
    ST_DEAD_LO,
    ST_LS_ON,
    ST_DE_BLANK,
    ST_DE_MON,
    ST_DE_DONE
  } seqState_t;

  // control -> timers
  typedef struct packed {
    logic loadDead;
    logic loadBlank;
    logic armTimeout;
    logic clearTimeout;
  } seqStrobe_t;

  // timers -> control
  typedef struct packed {
    logic deadDone;
    logic blankDone;
    logic timeoutHit;
  } seqStatus_t;

  // 00 low, 01 mid, 10 high, 11 handled as mid
  function automatic tgt_t decodePwm(logic [1:0] code);
    case (code)
      2'b00:   return TGT_LOW;
      2'b10:   return TGT_HIGH;
      default: return TGT_MID;
    endcase
  endfunction

endpackage

// File: rtl/tri_pwm_downcnt.sv
module tri_pwm_downcnt #(
  parameter int unsigned COUNT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic clear,
  output logic done
);
  localparam int unsigned W = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [W-1:0] START = W'(COUNT - 1);

  logic [W-1:0] cnt;
  logic         active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (clear) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= START;
      active <= 1'b1;
    end else if (active && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = active && (cnt == '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= START) else $error("counter beyond start value"); // R3

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    (load && !clear) |=> (active && cnt == START)) else $error("load not taken"); // R8

endmodule

// File: rtl/tri_pwm_timers.sv
module tri_pwm_timers
  import tri_pwm_pkg::*;
#(
  parameter int unsigned DEAD_CYC    = 3,
  parameter int unsigned BLANK_CYC   = 13,
  parameter int unsigned TIMEOUT_CYC = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output seqStatus_t status
);
  localparam int NUM_CNT = 3;

  function automatic int unsigned lenOf(int idx);
    case (idx)
      0:       return DEAD_CYC;
      1:       return BLANK_CYC;
      default: return TIMEOUT_CYC;
    endcase
  endfunction

  logic [NUM_CNT-1:0] ldVec;
  logic [NUM_CNT-1:0] clrVec;
  logic [NUM_CNT-1:0] doneVec;

  assign ldVec  = {strb.armTimeout, strb.loadBlank, strb.loadDead};
  assign clrVec = {strb.clearTimeout, 1'b0, 1'b0};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    tri_pwm_downcnt #(.COUNT(lenOf(i))) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .load (ldVec[i]),
      .clear(clrVec[i]),
      .done (doneVec[i])
    );
  end

  assign status.deadDone   = doneVec[0];
  assign status.blankDone  = doneVec[1];
  assign status.timeoutHit = doneVec[2];

endmodule

// File: rtl/tri_pwm_ctrl.sv
module tri_pwm_ctrl
  import tri_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] pwmCode,
  input  logic       swLow,
  input  logic       lsGateOff,
  input  logic       hsGateOff,
  input  logic       zeroCross,
  input  seqStatus_t status,
  output seqStrobe_t strb,
  output logic       hsGate,
  output logic       lsGate
);
  seqState_t state, stNext;
  tgt_t      tgt;
  logic      pwmWasHigh;

  assign tgt = decodePwm(pwmCode);

  always_comb begin
    stNext = state;
    strb   = '0;
    strb.armTimeout   = enable && pwmWasHigh && (tgt != TGT_HIGH);
    strb.clearTimeout = !enable || (tgt == TGT_HIGH);
    if (!enable) begin
      stNext = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          stNext = (tgt == TGT_HIGH) ? ST_WAIT_LS_OFF : ST_WAIT_HS_OFF;
        end
        ST_WAIT_LS_OFF: begin
          if (tgt != TGT_HIGH) begin
            stNext = ST_WAIT_HS_OFF;
          end else if (lsGateOff) begin
            stNext        = ST_DEAD_HI;
            strb.loadDead = 1'b1;
          end
        end
        ST_DEAD_HI: begin
          if (tgt != TGT_HIGH)      stNext = ST_WAIT_HS_OFF;
          else if (status.deadDone) stNext = ST_HS_ON;
        end
        ST_HS_ON: begin
          if (tgt != TGT_HIGH) stNext = ST_WAIT_HS_OFF;
        end
        ST_WAIT_HS_OFF: begin
          if (tgt == TGT_HIGH) begin
            stNext = ST_WAIT_LS_OFF;
          end else if (status.timeoutHit) begin
            strb.clearTimeout = 1'b1;
            if (tgt == TGT_MID) begin
              stNext         = ST_DE_BLANK;
              strb.loadBlank = 1'b1;
            end else begin
              stNext = ST_LS_ON;
            end
          end else if (hsGateOff && swLow) begin
            stNext        = ST_DEAD_LO;
            strb.loadDead = 1'b1;
          end
        end
        ST_DEAD_LO: begin
          if (tgt == TGT_HIGH) begin
            stNext = ST_WAIT_LS_OFF;
          end else if (status.deadDone) begin
            strb.clearTimeout = 1'b1;
            if (tgt == TGT_MID) begin
              stNext         = ST_DE_BLANK;
              strb.loadBlank = 1'b1;
            end else begin
              stNext = ST_LS_ON;
            end
          end
        end
        ST_LS_ON: begin
          if (tgt == TGT_HIGH) begin
            stNext = ST_WAIT_LS_OFF;
          end else if (tgt == TGT_MID) begin
            stNext         = ST_DE_BLANK;
            strb.loadBlank = 1'b1;
          end
        end
        ST_DE_BLANK: begin
          if (tgt == TGT_HIGH)       stNext = ST_WAIT_LS_OFF;
          else if (tgt == TGT_LOW)   stNext = ST_LS_ON;
          else if (status.blankDone) stNext = ST_DE_MON;
        end
        ST_DE_MON: begin
          if (tgt == TGT_HIGH)     stNext = ST_WAIT_LS_OFF;
          else if (tgt == TGT_LOW) stNext = ST_LS_ON;
          else if (zeroCross)      stNext = ST_DE_DONE;
        end
        ST_DE_DONE: begin
          if (tgt == TGT_HIGH)     stNext = ST_WAIT_LS_OFF;
          else if (tgt == TGT_LOW) stNext = ST_WAIT_HS_OFF;
        end
        default: stNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OFF;
      pwmWasHigh <= 1'b0;
    end else begin
      state      <= stNext;
      pwmWasHigh <= (tgt == TGT_HIGH);
    end
  end

  assign hsGate = (state == ST_HS_ON);
  assign lsGate = (state == ST_LS_ON) || (state == ST_DE_BLANK) || (state == ST_DE_MON);

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!hsGate && !lsGate)) else $error("gate on while disabled"); // R1

  AST_HS_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> $past(status.deadDone && !lsGate)) else $error("high side skipped dead time"); // R2

  AST_LS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsGate) |-> $past((status.deadDone || status.timeoutHit) && !hsGate)) else $error("low side rose without cause"); // R8

  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DE_BLANK && enable && tgt == TGT_MID) |=> lsGate) else $error("low side dropped in blanking"); // R5

  AST_ZC_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DE_MON && enable && tgt == TGT_MID && zeroCross) |=> (!lsGate && !hsGate)) else $error("zero cross not honoured"); // R6

endmodule

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq
  import tri_pwm_pkg::*;
#(
  parameter int unsigned DEAD_CYC    = 3,
  parameter int unsigned BLANK_CYC   = 13,
  parameter int unsigned TIMEOUT_CYC = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] pwmCode,
  input  logic       swLow,
  input  logic       lsGateOff,
  input  logic       hsGateOff,
  input  logic       zeroCross,
  output logic       hsGate,
  output logic       lsGate
);
  seqStrobe_t strb;
  seqStatus_t status;

  tri_pwm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .pwmCode  (pwmCode),
    .swLow    (swLow),
    .lsGateOff(lsGateOff),
    .hsGateOff(hsGateOff),
    .zeroCross(zeroCross),
    .status   (status),
    .strb     (strb),
    .hsGate   (hsGate),
    .lsGate   (lsGate)
  );

  tri_pwm_timers #(
    .DEAD_CYC   (DEAD_CYC),
    .BLANK_CYC  (BLANK_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timers (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .status(status)
  );

endmodule

// File: tb/tri_pwm_gate_seq_tb.sv
module tri_pwm_gate_seq_tb_top;
  localparam int D  = 3;
  localparam int B  = 5;
  localparam int TO = 8;
  localparam logic [1:0] P_LOW = 2'b00, P_MID = 2'b01, P_HIGH = 2'b10, P_ALT = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] pwmCode = P_LOW;
  logic zeroCross = 1'b0;
  logic holdLs = 1'b0, holdHs = 1'b0, swStuck = 1'b0;
  logic hsGate, lsGate;
  logic lsGateOff, hsGateOff, swLow;

  // simple power-stage model: senses follow the commands unless held
  assign lsGateOff = ~lsGate & ~holdLs;
  assign hsGateOff = ~hsGate & ~holdHs;
  assign swLow     = ~hsGate & ~swStuck;

  always #10 clk = ~clk;

  tri_pwm_gate_seq #(.DEAD_CYC(D), .BLANK_CYC(B), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .pwmCode(pwmCode),
    .swLow(swLow), .lsGateOff(lsGateOff), .hsGateOff(hsGateOff),
    .zeroCross(zeroCross), .hsGate(hsGate), .lsGate(lsGate));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, overlaps = 0, es = 0;
  bit finished = 1'b0;

  typedef struct {int at; logic hs; logic ls; string tag;} exp_t;
  exp_t q[$];

  task automatic chk(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %s expected %s", tag, cyc, act, exp);
    end
  endtask

  task automatic expectAt(int at, logic hs, logic ls, string tag);
    exp_t e;
    e.at = at; e.hs = hs; e.ls = ls; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pop and compare as the design produces results
  always @(negedge clk) begin
    if (hsGate && lsGate) overlaps++;
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(hsGate === e.hs && lsGate === e.ls, e.tag,
          $sformatf("hs=%b ls=%b", hsGate, lsGate), $sformatf("hs=%b ls=%b", e.hs, e.ls));
    end
  end

  task automatic setPwm(logic [1:0] v);
    pwmCode = v;
    es = cyc + 1;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic goHigh();
    setPwm(P_HIGH);
    expectAt(es + D, 1'b0, 1'b0, "R3");
    expectAt(es + 1 + D, 1'b1, 1'b0, "R3");
    drain();
  endtask

  task automatic goLow();
    setPwm(P_LOW);
    expectAt(es, 1'b0, 1'b0, "R4");
    expectAt(es + 1 + D, 1'b0, 1'b1, "R4");
    drain();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(hsGate === 1'b0 && lsGate === 1'b0, "R11", $sformatf("hs=%b ls=%b", hsGate, lsGate), "hs=0 ls=0");
    rstN = 1'b1; enable = 1'b1;
    goLow();            // R4 from the off state
    goHigh();           // R3
    goLow();            // R4, adaptive path well before timeout

    // R7 and R5: low -> mid keeps the low side on; zero cross ignored in blanking
    zeroCross = 1'b1;
    setPwm(P_MID);
    expectAt(es, 1'b0, 1'b1, "R7");
    expectAt(es + B, 1'b0, 1'b1, "R5");
    expectAt(es + B + 1, 1'b0, 1'b0, "R6");
    expectAt(es + B + 4, 1'b0, 1'b0, "R6");
    drain();

    // R7: low clears zero-cross state, next mid blanks again
    goLow();
    setPwm(P_MID);
    expectAt(es + B, 1'b0, 1'b1, "R7");
    expectAt(es + B + 1, 1'b0, 1'b0, "R7");
    drain();
    zeroCross = 1'b0;

    // R5/R6 from the high side
    goHigh();
    setPwm(P_MID);
    expectAt(es, 1'b0, 1'b0, "R5");
    expectAt(es + 1 + D, 1'b0, 1'b1, "R5");
    expectAt(es + 1 + D + B + 3, 1'b0, 1'b1, "R5");
    drain();
    waitUntil(es + 1 + D + B + 3);
    zeroCross = 1'b1;
    expectAt(cyc + 1, 1'b0, 1'b0, "R6");
    drain();
    zeroCross = 1'b0;
    goLow();

    // R8: switch node stuck high, backup timer turns the low side on
    goHigh();
    swStuck = 1'b1;
    setPwm(P_LOW);
    expectAt(es + TO - 1, 1'b0, 1'b0, "R8");
    expectAt(es + TO, 1'b0, 1'b1, "R8");
    drain();
    swStuck = 1'b0;

    // R8: expiry and adaptive condition in the same cycle, expiry wins
    goHigh();
    swStuck = 1'b1;
    setPwm(P_LOW);
    waitUntil(es + TO - 1);
    swStuck = 1'b0;
    expectAt(es + TO, 1'b0, 1'b1, "R8");
    drain();

    // R3: high side waits for the low-side sensor
    holdLs = 1'b1;
    setPwm(P_HIGH);
    expectAt(es + 1 + D + 2, 1'b0, 1'b0, "R3");
    drain();
    waitUntil(es + 6);
    holdLs = 1'b0;
    expectAt(cyc + D, 1'b0, 1'b0, "R3");
    expectAt(cyc + 1 + D, 1'b1, 1'b0, "R3");
    drain();

    // R4: low side waits for the high-side sensor
    holdHs = 1'b1;
    setPwm(P_LOW);
    waitUntil(es + 2);
    holdHs = 1'b0;
    expectAt(cyc + D, 1'b0, 1'b0, "R4");
    expectAt(cyc + 1 + D, 1'b0, 1'b1, "R4");
    drain();

    // R9: code change during the high-side dead time restarts with both off
    setPwm(P_HIGH);
    waitUntil(es + 1);
    pwmCode = P_LOW;
    expectAt(es + 1 + D, 1'b0, 1'b0, "R9");
    expectAt(es + 2 + D, 1'b0, 1'b0, "R9");
    expectAt(es + 3 + D, 1'b0, 1'b1, "R9");
    drain();

    // R10: code 11 behaves as mid
    setPwm(P_ALT);
    expectAt(es, 1'b0, 1'b1, "R10");
    expectAt(es + B + 2, 1'b0, 1'b1, "R10");
    drain();
    zeroCross = 1'b1;
    expectAt(cyc + 1, 1'b0, 1'b0, "R10");
    drain();
    zeroCross = 1'b0;
    goLow();

    // R1: disable forces both off, PWM ignored, restart on enable
    goHigh();
    enable = 1'b0;
    es = cyc + 1;
    expectAt(es, 1'b0, 1'b0, "R1");
    drain();
    pwmCode = P_LOW;
    repeat (4) @(negedge clk);
    chk(hsGate === 1'b0 && lsGate === 1'b0, "R1", $sformatf("hs=%b ls=%b", hsGate, lsGate), "hs=0 ls=0");
    enable = 1'b1;
    es = cyc + 1;
    expectAt(es + D, 1'b0, 1'b0, "R1");
    expectAt(es + 1 + D, 1'b0, 1'b1, "R1");
    drain();

    chk(overlaps == 0, "R2", $sformatf("%0d overlap cycles", overlaps), "0 overlap cycles");
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule